// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller with Acknowledge Vector

This block holds two 8-line interrupt resolvers. One is the primary, which drives the processor interrupt request. The other is the secondary. Its "has a winner" condition is fed into primary line 2. Each resolver keeps three 8-bit registers: requests, mask and in-service. It has a per-line edge or level trigger selection and a fixed priority in which the lowest line number wins. A line wins only if its priority is higher than every line already in service.

A one-cycle acknowledge strobe marks the winning line as in service and latches an 8-bit vector. When the primary winner is the cascade line, the secondary is resolved and acknowledged in the same cycle, and the vector comes from the secondary. When a resolver has nothing to deliver, it returns its base with line 7 as the spurious vector. A small byte-wide I/O port map gives access to both resolvers' command and mask ports and to their trigger-select registers. Each trigger-select register has a fixed write mask.

Top module: `dual_pic_ack`

## Requirements
- R1: After reset, `int_out` is 0, `vector` is 0x00, and the mask registers and trigger-select registers of both resolvers read 0x00.
- R2: A rising edge on an edge-mode line sets its request bit. `int_out` rises when an unmasked request outranks everything in service, and lower line numbers win. The vector is the primary base plus the winning line.
- R3: An acknowledge sets the winner's in-service bit and clears its edge-mode request bit. `int_out` is recomputed right away, so it drops while a lower-priority request waits behind the line in service.
- R4: A pending secondary request sets primary line 2 and raises `int_out`. An acknowledge then sets primary in-service bit 2 and the secondary winner's in-service bit, and returns the secondary base plus the secondary line.
- R5: When the primary winner is line 2 and the secondary has no winner, the acknowledge returns the secondary base plus 7 and leaves the secondary in-service register at 0.
- R6: An acknowledge with no primary winner returns the primary base plus 7 and changes no in-service bit.
- R7: Address 0x20/0x21 reaches the primary and 0xA0/0xA1 reaches the secondary. Address bit 7 selects the resolver and bit 0 selects the port. Port 1 reads the mask. Port 0 reads the requests, or the in-service register after a port-0 write of 0x0B; 0x0A selects requests again.
- R8: The trigger-select registers are at 0x4D0 (primary) and 0x4D1 (secondary). A write stores the data ANDed with 0xF8 for the primary and with 0xDE for the secondary. Bit n = 1 makes line n level-sensitive.
- R9: For a level-mode line, the request bit follows the input and is not cleared by an acknowledge.
- R10: Any address other than these six changes no register, and a read of it returns 0x00.
- R11: A port-0 write with bit 4 set clears the mask, request and in-service registers. The next three port-1 writes are taken as the base (bits 7:3 kept), the cascade word, and a mode word; the mode word is expected only if bit 0 of the first write was 1. Port-1 writes after that set the mask.
- R12: A port-0 write of 0x20 clears the highest-priority in-service bit. A write of 0x60+n clears in-service bit n.
- R13: A masked request line never wins and does not raise `int_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Raw request lines; bits 7:0 primary, 15:8 secondary |
| bus_addr | input | ADDR_W | I/O byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe (no side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when not reading or not decoded |
| inta | input | 1 | Acknowledge strobe, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector latched by the last acknowledge |

## Verification
The hardest state to reach is the spurious secondary acknowledge. Primary line 2 must be pending while the secondary has nothing left to deliver. Primary line 2 keeps its request once the secondary has raised it, so the bench makes a secondary line level-sensitive, raises it until the primary picks up the cascade request, then drops it before acknowledging. Cascade timing also matters: the primary sees the secondary's request one cycle after the secondary registers it, so checks wait several cycles after each stimulus.

// File: rtl/dual_pic_pkg.sv
package dual_pic_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);

  typedef enum logic [1:0] {IS_RUN, IS_BASE, IS_CASC, IS_MODE} init_st_t;

  typedef struct packed {
    logic ctl;
    logic trg;
    logic inst;
    logic port;
  } pic_sel_t;

  // Index of the lowest set bit, which is the highest priority.
  function automatic logic [IDX_W-1:0] low_idx(input logic [LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/pic_decode.sv
module pic_decode
  import dual_pic_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output pic_sel_t          sel
);
  localparam logic [ADDR_W-1:0] TRG_BASE = ADDR_W'('h4D0);

  logic ctl_hit, trg_hit;

  // Control ports: 0x20/0x21 and 0xA0/0xA1, with bit 7 ignored for the match.
  assign ctl_hit = (addr[ADDR_W-1:8] == '0) && (addr[6:1] == 6'b010000);
  assign trg_hit = (addr[ADDR_W-1:1] == TRG_BASE[ADDR_W-1:1]);

  always_comb begin
    sel.ctl  = ctl_hit;
    sel.trg  = trg_hit;
    sel.inst = ctl_hit ? addr[7] : addr[0];
    sel.port = addr[0];
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import dual_pic_pkg::*;
#(
  parameter logic [LINES-1:0] TRIG_MASK = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] cas_set,
  input  logic             ctl_wr,
  input  logic             ctl_port,
  input  logic             trg_wr,
  input  logic [7:0]       wdata,
  input  logic             ack,
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx,
  output logic [4:0]       base,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] imr,
  output logic [LINES-1:0] isr,
  output logic [LINES-1:0] trig,
  output logic             rsel
);
  logic [LINES-1:0] irr_q, irr_n, last_q, last_n, imr_q, imr_n;
  logic [LINES-1:0] isr_q, isr_n, trig_q, trig_n, irr_nx, ack_bit;
  logic [4:0]       base_q, base_n;
  logic             rsel_q, rsel_n, need4_q, need4_n;
  init_st_t         ist_q, ist_n;

  logic [LINES-1:0] req;
  logic [IDX_W-1:0] req_idx, svc_idx;
  logic             svc_vld;

  // Priority resolution
  assign req     = irr_q & ~imr_q;
  assign req_idx = low_idx(req);
  assign svc_idx = low_idx(isr_q);
  assign svc_vld = |isr_q;
  assign win_vld = (|req) && (!svc_vld || (req_idx < svc_idx));
  assign win_idx = req_idx;
  assign ack_bit = ack ? (LINES'(1) << win_idx) : '0;

  // Per-line request update
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irr_nx[i] = trig_q[i] ? lines[i]
                     : ((irr_q[i] | (lines[i] & ~last_q[i]) | cas_set[i]) & ~ack_bit[i]);
  end

  always_comb begin
    irr_n   = irr_nx;
    last_n  = lines;
    imr_n   = imr_q;
    isr_n   = isr_q | ack_bit;
    trig_n  = trg_wr ? (wdata & TRIG_MASK) : trig_q;
    base_n  = base_q;
    rsel_n  = rsel_q;
    ist_n   = ist_q;
    need4_n = need4_q;
    if (ctl_wr) begin
      if (!ctl_port) begin
        if (wdata[4]) begin
          irr_n   = '0;
          last_n  = '0;
          imr_n   = '0;
          isr_n   = '0;
          base_n  = '0;
          rsel_n  = 1'b0;
          ist_n   = IS_BASE;
          need4_n = wdata[0];
        end else if (wdata[3]) begin
          if (wdata[1]) rsel_n = wdata[0];
        end else if (wdata[7:5] == 3'b001) begin
          if (svc_vld) isr_n[svc_idx] = 1'b0;
        end else if (wdata[7:5] == 3'b011) begin
          isr_n[wdata[2:0]] = 1'b0;
        end
      end else begin
        case (ist_q)
          IS_RUN:  imr_n = wdata;
          IS_BASE: begin base_n = wdata[7:3]; ist_n = IS_CASC; end
          IS_CASC: ist_n = need4_q ? IS_MODE : IS_RUN;
          default: ist_n = IS_RUN;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q   <= '0;
      last_q  <= '0;
      imr_q   <= '0;
      isr_q   <= '0;
      trig_q  <= '0;
      base_q  <= '0;
      rsel_q  <= 1'b0;
      need4_q <= 1'b0;
      ist_q   <= IS_RUN;
    end else begin
      irr_q   <= irr_n;
      last_q  <= last_n;
      imr_q   <= imr_n;
      isr_q   <= isr_n;
      trig_q  <= trig_n;
      base_q  <= base_n;
      rsel_q  <= rsel_n;
      need4_q <= need4_n;
      ist_q   <= ist_n;
    end
  end

  assign irr  = irr_q;
  assign imr  = imr_q;
  assign isr  = isr_q;
  assign trig = trig_q;
  assign base = base_q;
  assign rsel = rsel_q;
endmodule

// File: rtl/dual_pic_ack.sv
module dual_pic_ack
  import dual_pic_pkg::*;
#(
  parameter int               ADDR_W           = 16,
  parameter int               CAS_LINE         = 2,
  parameter logic [LINES-1:0] MASTER_TRIG_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLAVE_TRIG_MASK  = 8'hDE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*LINES-1:0]   irq_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic                 inta,
  output logic                 int_out,
  output logic [7:0]           vector
);
  localparam int NUM = 2;

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  pic_sel_t         sel;
  logic             win_vld [NUM];
  logic [IDX_W-1:0] win_idx [NUM];
  logic [4:0]       base_a  [NUM];
  logic [LINES-1:0] irr_a [NUM], imr_a [NUM], isr_a [NUM], trig_a [NUM];
  logic             rsel_a  [NUM];
  logic             ack_a   [NUM];
  logic [LINES-1:0] cas_vec;
  logic [7:0]       vec_q, vec_n;

  // Reset: asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  pic_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  assign cas_vec = win_vld[1] ? (LINES'(1) << CAS_LINE) : '0;
  assign ack_a[0] = inta && win_vld[0];
  assign ack_a[1] = ack_a[0] && (win_idx[0] == IDX_W'(CAS_LINE)) && win_vld[1];

  for (genvar g = 0; g < NUM; g++) begin : g_pic
    pic_core #(
      .TRIG_MASK((g == 0) ? MASTER_TRIG_MASK : SLAVE_TRIG_MASK)
    ) u_core (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .lines   (irq_in[g*LINES +: LINES]),
      .cas_set ((g == 0) ? cas_vec : '0),
      .ctl_wr  (bus_wr && sel.ctl && (sel.inst == 1'(g))),
      .ctl_port(sel.port),
      .trg_wr  (bus_wr && sel.trg && (sel.inst == 1'(g))),
      .wdata   (bus_wdata),
      .ack     (ack_a[g]),
      .win_vld (win_vld[g]),
      .win_idx (win_idx[g]),
      .base    (base_a[g]),
      .irr     (irr_a[g]),
      .imr     (imr_a[g]),
      .isr     (isr_a[g]),
      .trig    (trig_a[g]),
      .rsel    (rsel_a[g])
    );
  end

  // Acknowledge vector selection
  always_comb begin
    if (!win_vld[0])
      vec_n = {base_a[0], 3'd7};
    else if (win_idx[0] == IDX_W'(CAS_LINE))
      vec_n = win_vld[1] ? {base_a[1], win_idx[1]} : {base_a[1], 3'd7};
    else
      vec_n = {base_a[0], win_idx[0]};
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  vec_q <= '0;
    else if (inta) vec_q <= vec_n;
  end

  // Read data mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel.ctl) begin
        if (sel.port)              bus_rdata = imr_a[sel.inst];
        else if (rsel_a[sel.inst]) bus_rdata = isr_a[sel.inst];
        else                       bus_rdata = irr_a[sel.inst];
      end else if (sel.trg) begin
        bus_rdata = trig_a[sel.inst];
      end
    end
  end

  assign int_out = win_vld[0];
  assign vector  = vec_q;

  logic [LINES-1:0] m_irr, m_imr, m_isr, m_trig, s_trig;
  assign m_irr  = irr_a[0];
  assign m_imr  = imr_a[0];
  assign m_isr  = isr_a[0];
  assign m_trig = trig_a[0];
  assign s_trig = trig_a[1];
endmodule

// File: rtl/dual_pic_chk.sv
module dual_pic_chk #(
  parameter int       ADDR_W = 16,
  parameter logic [7:0] MT   = 8'hF8,
  parameter logic [7:0] ST   = 8'hDE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inta,
  input logic              int_out,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        vector,
  input logic [7:0]        m_irr,
  input logic [7:0]        m_imr,
  input logic [7:0]        m_isr,
  input logic [7:0]        m_trig,
  input logic [7:0]        s_trig
);
  logic mapped;
  assign mapped = (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'('h10))
               || (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'('h50))
               || (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'('h268));

  // R2 / R13: no unmasked request means no interrupt to the processor
  p_no_req_no_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_irr & ~m_imr) == 8'h00) |-> !int_out);

  // R3: a delivered acknowledge leaves something in service
  p_ack_marks_isr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !bus_wr) |=> (m_isr != 8'h00));

  // R6: acknowledge with no winner yields line 7 and keeps in-service state
  p_spurious_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !bus_wr) |=> ((vector[2:0] == 3'd7) && $stable(m_isr)));

  // R8: trigger registers never hold bits outside their fixed masks
  p_trig_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_trig & ~MT) == 8'h00) && ((s_trig & ~ST) == 8'h00));

  // R10: reads of undecoded addresses return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |-> (bus_rdata == 8'h00));
endmodule

bind dual_pic_ack dual_pic_chk #(
  .ADDR_W(ADDR_W), .MT(MASTER_TRIG_MASK), .ST(SLAVE_TRIG_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .inta     (inta),
  .int_out  (int_out),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .vector   (vector),
  .m_irr    (m_irr),
  .m_imr    (m_imr),
  .m_isr    (m_isr),
  .m_trig   (m_trig),
  .s_trig   (s_trig)
);

// File: tb/dual_pic_ack_tb.sv
`timescale 1ns/1ps
module dual_pic_ack_tb;
  logic        clk, rst_n, bus_wr, bus_rd, inta, int_out;
  logic [15:0] irq_in, bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, vector;
  int          n_chk, n_fail;
  bit          done;

  dual_pic_ack u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .inta(inta), .int_out(int_out), .vector(vector)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_isr(input logic [15:0] a, output logic [7:0] d);
    wr(a, 8'h0B);
    rd(a, d);
    wr(a, 8'h0A);
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    v = vector;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 vector", vector, 8'h00);
    rd(16'h0021, d); chk("R1 primary mask", d, 8'h00);
    rd(16'h00A1, d); chk("R1 secondary mask", d, 8'h00);
    rd(16'h04D0, d); chk("R1 trigger reg", d, 8'h00);
  endtask

  task automatic t_init;
    logic [7:0] d;
    wr(16'h0021, 8'h33);
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h0B); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
    rd(16'h0021, d); chk("R11 init clears mask", d, 8'h00);
    wr(16'h0021, 8'hFF); rd(16'h0021, d); chk("R11 mask after 4 words", d, 8'hFF);
    wr(16'h0021, 8'h00);
    wr(16'h00A0, 8'h10); wr(16'h00A1, 8'h70); wr(16'h00A1, 8'h02);
    wr(16'h00A1, 8'h5A); rd(16'h00A1, d); chk("R11 mask after 3 words", d, 8'h5A);
    wr(16'h00A1, 8'h00);
  endtask

  task automatic t_trigger;
    logic [7:0] d;
    wr(16'h04D0, 8'hFF); rd(16'h04D0, d); chk("R8 primary trig mask", d, 8'hF8);
    wr(16'h04D1, 8'hFF); rd(16'h04D1, d); chk("R8 secondary trig mask", d, 8'hDE);
    wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h00);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(16'h0022, 8'hFF); wr(16'h0121, 8'hFF); wr(16'h04D2, 8'hFF); wr(16'h01A1, 8'hFF);
    rd(16'h0021, d); chk("R10 primary mask untouched", d, 8'h00);
    rd(16'h00A1, d); chk("R10 secondary mask untouched", d, 8'h00);
    rd(16'h04D0, d); chk("R10 trig untouched", d, 8'h00);
    rd(16'h0022, d); chk("R10 unmapped read", d, 8'h00);
    rd(16'h0121, d); chk("R10 high-bit alias read", d, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] d, v;
    irq_in[5] = 1'b1; irq_in[3] = 1'b1;
    idle(3);
    chk("R2 int_out raised", {7'd0, int_out}, 8'h01);
    rd(16'h0020, d); chk("R7 request read", d, 8'h28);
    ack(v); chk("R2 priority vector", v, 8'h0B);
    chk("R3 int blocked by in-service", {7'd0, int_out}, 8'h00);
    rd_isr(16'h0020, d); chk("R3 in-service set", d, 8'h08);
    rd(16'h0020, d); chk("R3 edge request cleared", d, 8'h20);
    wr(16'h0020, 8'h20);
    chk("R12 nonspecific EOI reopens", {7'd0, int_out}, 8'h01);
    ack(v); chk("R2 next vector", v, 8'h0D);
    wr(16'h0020, 8'h65);
    rd_isr(16'h0020, d); chk("R12 specific EOI", d, 8'h00);
    irq_in[5] = 1'b0; irq_in[3] = 1'b0;
    idle(2);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(16'h0021, 8'h10);
    irq_in[4] = 1'b1;
    idle(3);
    chk("R13 masked line silent", {7'd0, int_out}, 8'h00);
    wr(16'h0021, 8'h00);
    chk("R13 unmasked raises", {7'd0, int_out}, 8'h01);
    ack(v); chk("R13 vector after unmask", v, 8'h0C);
    wr(16'h0020, 8'h20);
    irq_in[4] = 1'b0;
    idle(2);
  endtask

  task automatic t_cascade;
    logic [7:0] d, v;
    irq_in[12] = 1'b1;
    idle(4);
    chk("R4 cascade raises int", {7'd0, int_out}, 8'h01);
    ack(v); chk("R4 secondary vector", v, 8'h74);
    rd_isr(16'h0020, d); chk("R4 primary in-service line 2", d, 8'h04);
    rd_isr(16'h00A0, d); chk("R4 secondary in-service", d, 8'h10);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    irq_in[12] = 1'b0;
    idle(3);
    chk("R4 quiet after EOI", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_spurious_slave;
    logic [7:0] d, v;
    wr(16'h04D1, 8'h02);
    irq_in[9] = 1'b1;
    idle(4);
    chk("R5 cascade pending", {7'd0, int_out}, 8'h01);
    irq_in[9] = 1'b0;
    idle(3);
    chk("R5 line 2 still pending", {7'd0, int_out}, 8'h01);
    ack(v); chk("R5 spurious secondary vector", v, 8'h77);
    rd_isr(16'h00A0, d); chk("R5 secondary in-service empty", d, 8'h00);
    wr(16'h0020, 8'h20); wr(16'h04D1, 8'h00);
    idle(2);
  endtask

  task automatic t_level;
    logic [7:0] d, v;
    wr(16'h04D0, 8'h08);
    irq_in[3] = 1'b1;
    idle(3);
    ack(v); chk("R9 level vector", v, 8'h0B);
    rd(16'h0020, d); chk("R9 request kept after ack", d, 8'h08);
    wr(16'h0020, 8'h20);
    chk("R9 level reasserts after EOI", {7'd0, int_out}, 8'h01);
    irq_in[3] = 1'b0;
    idle(2);
    rd(16'h0020, d); chk("R9 request follows level low", d, 8'h00);
    chk("R9 int drops with level", {7'd0, int_out}, 8'h00);
    wr(16'h04D0, 8'h00);
  endtask

  task automatic t_no_winner;
    logic [7:0] d, v;
    ack(v); chk("R6 spurious primary vector", v, 8'h0F);
    rd_isr(16'h0020, d); chk("R6 in-service unchanged", d, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; inta = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_init;
    t_trigger;
    t_unmapped;
    t_edge;
    t_mask;
    t_cascade;
    t_spurious_slave;
    t_level;
    t_no_winner;
    finish_run;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule